// File: doc/BRIEF.md
# IDE Interrupt Status and One-Way Forwarding Enable

This block gathers the interrupt request lines of two or three IDE ports. Each line is first brought into the local clock domain through a two-stage synchronizer. Software can then sample the live level of any port by reading a byte from a small register window. The block also merges the active lines onto a single host interrupt output, but only after software has opened a forwarding gate. Keeping the gate shut lets the host boot safely even when an attached drive holds its interrupt line asserted during its own start-up.

The block sits on a byte-wide slave bus and decodes the 256-byte page at offsets 0xF00 to 0xFFF. The page is split into four 64-byte slots, and every byte inside a slot is a mirror of the slot's first byte:
- slots 0 to 2 are read-only status bytes;
- slot 3 arms the gate on any write.

The gate cannot be closed by software, and its state cannot be read back; only reset closes it. A parameter selects either the three-port build or the two-port build. In the two-port build the third status slot always reports that no interrupt is pending.

Top module: `ide_irq_hub`

## Requirements
- R1: After reset, `rd_valid` is 0, `irq_out` is 0 and the forwarding gate is closed, whatever the levels on `irq_raw`.
- R2: A read anywhere in 0xF00–0xF3F (`bus_addr[11:8]`=0xF, `bus_addr[7:6]`=0) returns the synchronized level of port 0 in bit 7 of `rd_data`, with bits 6:0 equal to 0. `rd_valid` is high in the cycle after the read strobe.
- R3: A read anywhere in 0xF40–0xF7F (`bus_addr[7:6]`=1) returns the synchronized level of port 1 in bit 7 of `rd_data`, with bits 6:0 equal to 0.
- R4: A read anywhere in 0xF80–0xFBF (`bus_addr[7:6]`=2) returns the synchronized level of port 2 in bit 7 of `rd_data`. In the two-port build (`PORTS`=2) this read always returns 0x00.
- R5: A write of any data value anywhere in 0xFC0–0xFFF (`bus_addr[7:6]`=3) opens the forwarding gate from the next clock edge on.
- R6: Once the gate is open, it stays open through any later reads and writes. Only `rst` closes it.
- R7: `irq_out` is 1 exactly when the gate is open and at least one synchronized port line is 1. While the gate is closed, `irq_out` is 0.
- R8: A change on an `irq_raw` bit reaches the status bytes and `irq_out` after two rising clock edges, and not after one.
- R9: An access with `bus_addr[11:8]` other than 0xF produces no `rd_valid` and does not open the gate. A write to a status slot also does not open the gate.
- R10: A read in 0xFC0–0xFFF returns 0x00 with `rd_valid` high, whether or not the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | PORTS | Asynchronous interrupt request lines of the IDE ports, active high |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | ADDR_W | Byte offset of the access within the board's space |
| bus_wdata | input | 8 | Write data; its value has no effect |
| rd_valid | output | 1 | Read data valid, high in the cycle after a read that hits the page |
| rd_data | output | 8 | Read data byte |
| irq_out | output | 1 | Merged host interrupt request, active high |

## Verification
The properties assume that `bus_sel` is a single-cycle strobe and that `bus_addr` and `bus_we` are steady during that cycle. They also assume that `irq_raw` is an ordinary level signal; the synchronizer absorbs any metastability. The bench changes every input at the falling clock edge, so that no input moves near a rising edge. It holds each `irq_raw` pattern for at least two rising edges before it samples a status byte. Exceptions are the deliberate one-edge and two-edge probes of the synchronizer latency.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

    localparam int DATA_W    = 8;
    localparam int STAT_BIT  = 7;
    localparam int MAX_PORTS = 3;
    localparam int SLOT_W    = 2;
    localparam int PAGE_W    = 4;
    localparam logic [PAGE_W-1:0] PAGE_ID = 4'hF;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_P0  = 2'd0,
        SLOT_P1  = 2'd1,
        SLOT_P2  = 2'd2,
        SLOT_ARM = 2'd3
    } slot_e;

    typedef struct packed {
        logic  hit;
        logic  is_wr;
        slot_e slot;
    } bus_dec_t;

    function automatic logic [DATA_W-1:0] status_byte(input logic lvl);
        logic [DATA_W-1:0] b;
        b = '0;
        b[STAT_BIT] = lvl;
        return b;
    endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

    // R8: the stable stage only ever takes the value the first stage held one cycle earlier
    a_r8_two_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stab_q == $past(meta_q)));
endmodule

// File: rtl/irq_win_decode.sv
module irq_win_decode
    import ide_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_dec_t          dec
);
    localparam int PAGE_LSB = ADDR_W - PAGE_W;
    localparam int SLOT_LSB = PAGE_LSB - SLOT_W;

    logic unused_mirror_bits;
    assign unused_mirror_bits = ^bus_addr[SLOT_LSB-1:0];

    always_comb begin
        dec.hit   = bus_sel && (bus_addr[ADDR_W-1:PAGE_LSB] == PAGE_ID);
        dec.is_wr = bus_we;
        dec.slot  = slot_e'(bus_addr[PAGE_LSB-1:SLOT_LSB]);
    end
endmodule

// File: rtl/irq_arm_gate.sv
module irq_arm_gate #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm_wr,
    input  logic [W-1:0] lvl,
    output logic         irq_out
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (arm_wr)
            en_q <= 1'b1;
    end

    assign irq_out = en_q & (|lvl);

    a_r5_arm_sets: assert property (@(posedge clk) disable iff (rst)
        arm_wr |=> en_q);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        en_q |=> en_q);

    a_r7_blocked: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !irq_out);
endmodule

// File: rtl/ide_irq_hub.sv
module ide_irq_hub
    import ide_irq_pkg::*;
#(
    parameter int PORTS  = 3,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORTS-1:0]  irq_raw,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_out
);
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    logic [PORTS-1:0]     lvl_sync;
    logic [MAX_PORTS-1:0] lvl_pad;
    bus_dec_t             dec;
    logic                 arm_wr;
    logic                 rd_hit;
    logic [DATA_W-1:0]    rd_next;
    logic                 rd_valid_q;
    logic [DATA_W-1:0]    rd_data_q;

    irq_sync2 #(.W(PORTS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_raw),
        .q   (lvl_sync)
    );

    for (genvar i = 0; i < MAX_PORTS; i++) begin : g_pad
        if (i < PORTS) begin : g_live
            assign lvl_pad[i] = lvl_sync[i];
        end else begin : g_absent
            assign lvl_pad[i] = 1'b0;
        end
    end

    irq_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .dec      (dec)
    );

    assign arm_wr = dec.hit && dec.is_wr && (dec.slot == SLOT_ARM);
    assign rd_hit = dec.hit && !dec.is_wr;

    always_comb begin
        case (dec.slot)
            SLOT_P0: rd_next = status_byte(lvl_pad[0]);
            SLOT_P1: rd_next = status_byte(lvl_pad[1]);
            SLOT_P2: rd_next = status_byte(lvl_pad[2]);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_hit;
            if (rd_hit)
                rd_data_q <= rd_next;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    irq_arm_gate #(.W(MAX_PORTS)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .arm_wr  (arm_wr),
        .lvl     (lvl_pad),
        .irq_out (irq_out)
    );

    // R2 / R3 / R4: the unused status bits always read as zero
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[STAT_BIT-1:0] == '0));

    a_r9_miss_silent: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !dec.hit) |=> !rd_valid);

    a_r10_arm_hidden: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && dec.slot == SLOT_ARM) |=> (rd_valid && rd_data == '0));

    a_r4_absent_port: assert property (@(posedge clk) disable iff (rst)
        (PORTS < MAX_PORTS && rd_hit && dec.slot == SLOT_P2) |=> (rd_data == '0));
endmodule

// File: tb/sim_ide_irq_hub.sv
`timescale 1ns/1ps
module sim_ide_irq_hub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  irq_raw  = '0;
    logic [1:0]  irq_raw2 = '0;
    logic        bus_sel  = 1'b0;
    logic        bus_we   = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        rd_valid, rd_valid2;
    logic [7:0]  rd_data, rd_data2;
    logic        irq_out, irq_out2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    ide_irq_hub #(.PORTS(3), .ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .irq_raw(irq_raw),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_out(irq_out)
    );

    ide_irq_hub #(.PORTS(2), .ADDR_W(12)) u1 (
        .clk(clk), .rst(rst), .irq_raw(irq_raw2),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid2), .rd_data(rd_data2), .irq_out(irq_out2)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_irq(input logic [2:0] v, input logic [1:0] v2);
        @(negedge clk);
        irq_raw = v; irq_raw2 = v2;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expected byte per valid read
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected read data actual=%h expected=none", rd_data);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s read actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        irq_raw = 3'b111;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rd_valid after reset", {7'd0, rd_valid}, 8'd0);
        check("R1 irq_out after reset", {7'd0, irq_out}, 8'd0);

        set_irq(3'b000, 2'b00);
        bus_read(12'hF00, 8'h00, "R2 idle");
        bus_read(12'hF40, 8'h00, "R3 idle");
        bus_read(12'hF80, 8'h00, "R4 idle");

        set_irq(3'b001, 2'b11);
        bus_read(12'hF00, 8'h80, "R2 port0 high");
        bus_read(12'hF3F, 8'h80, "R2 port0 mirror");
        bus_read(12'hF40, 8'h00, "R3 port1 low");

        set_irq(3'b010, 2'b11);
        bus_read(12'hF7F, 8'h80, "R3 port1 mirror");
        bus_read(12'hF15, 8'h00, "R2 port0 low");

        set_irq(3'b100, 2'b11);
        bus_read(12'hF80, 8'h80, "R4 port2 high");
        checks++;
        if (!(rd_valid2 === 1'b1 && rd_data2 === 8'h00)) begin
            errors++;
            $display("FAIL R4 two-port slot2 actual=%b/%h expected=1/00", rd_valid2, rd_data2);
        end
        bus_read(12'hFBF, 8'h80, "R4 port2 mirror");

        set_irq(3'b111, 2'b11);
        check("R7 gate closed blocks", {7'd0, irq_out}, 8'd0);

        bus_write(12'hF00, 8'hFF);
        bus_write(12'hE00, 8'hFF);
        bus_write(12'h7C0, 8'hFF);
        @(negedge clk);
        check("R9 stray writes leave gate closed", {7'd0, irq_out}, 8'd0);
        bus_read(12'hE40, 8'h00, "R9 unused");
        void'(exp_q.pop_back());
        void'(tag_q.pop_back());
        check("R9 miss read no valid", {7'd0, rd_valid}, 8'd0);

        bus_read(12'hFC0, 8'h00, "R10 closed");

        bus_write(12'hFE7, 8'h00);
        check("R5 zero write arms", {7'd0, irq_out}, 8'd1);
        check("R7 two-port merge", {7'd0, irq_out2}, 8'd1);
        bus_read(12'hFFF, 8'h00, "R10 open");

        bus_write(12'hFC0, 8'h00);
        bus_read(12'hF00, 8'h80, "R6 read after arm");
        check("R6 still open", {7'd0, irq_out}, 8'd1);

        @(negedge clk);
        irq_raw = 3'b000;
        @(negedge clk);
        check("R8 one edge still old", {7'd0, irq_out}, 8'd1);
        @(negedge clk);
        check("R8 two edges new", {7'd0, irq_out}, 8'd0);
        irq_raw = 3'b010;
        @(negedge clk);
        check("R8 rise one edge", {7'd0, irq_out}, 8'd0);
        @(negedge clk);
        check("R7 single line forwards", {7'd0, irq_out}, 8'd1);

        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        set_irq(3'b111, 2'b11);
        check("R1 reset closes gate", {7'd0, irq_out}, 8'd0);
        check("R6 reset closes two-port gate", {7'd0, irq_out2}, 8'd0);

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule